// File: doc/BRIEF.md
# RAM Sweep Address Sequencer

This block produces the read address for a small lookup RAM whose entries are frequency or waveform words, so that the stored values can be stepped through over time. Four profile control words are held in shadow registers. Each word carries a start address, an end address, a step interval, a three-bit sweep kind and a flag that asks for the phase accumulator to be cleared once the sweep finishes. A pulse on `update` copies the configuration inputs into the shadow registers and restarts the sweep. The `profile` input chooses which control word drives the sweep.

A down-counting interval timer sets the pace. Each time it expires, the address moves by one step or stays where it is, according to the sweep kind. The kinds are: a one-shot rise, a direction-controlled sweep where `profile[0]` sets the direction, an automatic up-then-down triangle, and a wrapping upward sawtooth. On a one-shot rise the block can raise a completion flag, and it can also raise a sticky clear request for the phase accumulator.

Top module: `sweep_addr_seq`

## Requirements
- R1: A sweep starts at the second rising edge after `update` is sampled high. It also starts at the second edge after a changed `profile` value is sampled, except in direction-controlled operation. At the start, `ramAddr` takes the start address of the selected word and the interval timer is reloaded.
- R2: With step interval value R, the address can move only at edges R, 2R, 3R and so on after the start edge. An R of 0 behaves exactly like 1.
- R3: Sweep kind 3'b001 (one-shot rise) counts up by one per interval and stops at the end address. If the clear flag is 0, `sweepDone` rises together with the address reaching the end. The sweep stays there until the next start.
- R4: In one-shot rise with the clear flag set, the address stops at the end address. After one further interval at that address, `accClear` and `sweepDone` both rise. They stay high until the next start.
- R5: Sweep kind 3'b010 in profile word 0 selects direction-controlled operation. Only word 0 is used and `profile[1]` is ignored. With `profile[0]` high the address counts up and saturates at the end address. With it low the address counts down and saturates at the start address.
- R6: In direction-controlled operation, a sampled fall of `profile[0]` decrements the address at the next edge and reloads the timer. Toggling `profile` bits never restarts the sweep.
- R7: Sweep kind 3'b011 counts up to the end address, then down to the start address at the same interval, and repeats without end. The clear flag is ignored.
- R8: Sweep kind 3'b100 counts upward. After one interval spent at the end address it returns to the start address, and this repeats without end.
- R9: Any other sweep kind holds `ramAddr` at the start address. In every kind except one-shot rise, `sweepDone` and `accClear` stay low.
- R10: While `rstN` is low, `ramAddr`, `sweepDone` and `accClear` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| update | input | 1 | Latch configuration into shadow registers and restart |
| profile | input | PROF_W | Control word select; bit 0 is direction in direction-controlled operation |
| cfgBegin | input | NUM_PROF*ADDR_W | Start address per profile word |
| cfgFinal | input | NUM_PROF*ADDR_W | End address per profile word |
| cfgRate | input | NUM_PROF*RATE_W | Step interval per profile word |
| cfgMode | input | NUM_PROF*3 | Sweep kind per profile word |
| cfgNoDwell | input | NUM_PROF | Clear-on-finish flag per profile word |
| ramAddr | output | ADDR_W | RAM read address |
| sweepDone | output | 1 | One-shot sweep finished |
| accClear | output | 1 | Phase accumulator clear request (sticky) |

## Verification
The bench builds the block with ADDR_W=4, RATE_W=3 and NUM_PROF=4. This small configuration lets the bench sweep every interval value from 0 to 7 against several start and end pairs, including equal ends, for each non-directional sweep kind. Every triangle and wrap period completes within a few dozen cycles, so each one can be followed cycle by cycle against a closed-form expected address. Profile switching and the direction-controlled sequence are exercised as directed scenarios.

// File: rtl/sas_pkg.sv
package sas_pkg;

  localparam logic [2:0] CODE_RAMPUP = 3'b001;
  localparam logic [2:0] CODE_BIDIR  = 3'b010;
  localparam logic [2:0] CODE_CBIDIR = 3'b011;
  localparam logic [2:0] CODE_RECIRC = 3'b100;

  typedef enum logic [2:0] {
    KIND_HOLD,
    KIND_RAMPUP,
    KIND_BIDIR,
    KIND_CBIDIR,
    KIND_RECIRC
  } sweepKindT;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic load;    // address <= start address
    logic reload;  // interval timer <= interval value
    logic inc;     // address + 1
    logic dec;     // address - 1
    logic wrap;    // address <= start address (recirculate)
  } stepStbT;

  function automatic sweepKindT decodeKind(input logic [2:0] code);
    case (code)
      CODE_RAMPUP: return KIND_RAMPUP;
      CODE_BIDIR:  return KIND_BIDIR;
      CODE_CBIDIR: return KIND_CBIDIR;
      CODE_RECIRC: return KIND_RECIRC;
      default:     return KIND_HOLD;
    endcase
  endfunction

endpackage

// File: rtl/sas_cfg_bank.sv
module sas_cfg_bank #(
  parameter int NUM_PROF = 4,
  parameter int ADDR_W   = 10,
  parameter int RATE_W   = 16,
  parameter int PROF_W   = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       update,
  input  logic [NUM_PROF*ADDR_W-1:0] cfgBegin,
  input  logic [NUM_PROF*ADDR_W-1:0] cfgFinal,
  input  logic [NUM_PROF*RATE_W-1:0] cfgRate,
  input  logic [NUM_PROF*3-1:0]      cfgMode,
  input  logic [NUM_PROF-1:0]        cfgNoDwell,
  input  logic [PROF_W-1:0]          effSel,
  output logic [ADDR_W-1:0]          selBegin,
  output logic [ADDR_W-1:0]          selFinal,
  output logic [RATE_W-1:0]          selRate,
  output logic [2:0]                 selMode,
  output logic                       selNoDwell,
  output logic [2:0]                 word0Mode
);

  logic [ADDR_W-1:0] begQ   [NUM_PROF];
  logic [ADDR_W-1:0] finQ   [NUM_PROF];
  logic [RATE_W-1:0] rateQ  [NUM_PROF];
  logic [2:0]        modeQ  [NUM_PROF];
  logic [NUM_PROF-1:0] ndQ;

  // Shadow copy of every profile word, loaded only on the update strobe
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int p = 0; p < NUM_PROF; p++) begin
        begQ[p]  <= '0;
        finQ[p]  <= '0;
        rateQ[p] <= '0;
        modeQ[p] <= '0;
      end
      ndQ <= '0;
    end else if (update) begin
      for (int p = 0; p < NUM_PROF; p++) begin
        begQ[p]  <= cfgBegin[p*ADDR_W +: ADDR_W];
        finQ[p]  <= cfgFinal[p*ADDR_W +: ADDR_W];
        rateQ[p] <= cfgRate[p*RATE_W +: RATE_W];
        modeQ[p] <= cfgMode[p*3 +: 3];
      end
      ndQ <= cfgNoDwell;
    end
  end

  always_comb begin
    selBegin   = begQ[effSel];
    selFinal   = finQ[effSel];
    selRate    = rateQ[effSel];
    selMode    = modeQ[effSel];
    selNoDwell = ndQ[effSel];
    word0Mode  = modeQ[0];
  end

endmodule

// File: rtl/sas_datapath.sv
module sas_datapath
  import sas_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  stepStbT           stb,
  input  logic [ADDR_W-1:0] selBegin,
  input  logic [ADDR_W-1:0] selFinal,
  input  logic [RATE_W-1:0] selRate,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              timerExpire,
  output logic              atBegin,
  output logic              atFinal,
  output logic              atPreFinal,
  output logic              sameEnds
);

  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
  localparam logic [RATE_W-1:0] RATE_ONE = RATE_W'(1);

  logic [RATE_W-1:0] tmrQ;
  logic [RATE_W-1:0] rateEff;
  logic [ADDR_W-1:0] addrQ;

  // An interval of zero is promoted to one
  assign rateEff = (selRate == '0) ? RATE_ONE : selRate;

  always_ff @(posedge clk) begin
    if (!rstN)              tmrQ <= '0;
    else if (stb.reload)    tmrQ <= rateEff;
    else if (tmrQ > RATE_ONE) tmrQ <= tmrQ - RATE_ONE;
  end

  assign timerExpire = (tmrQ <= RATE_ONE);

  always_ff @(posedge clk) begin
    if (!rstN)                   addrQ <= '0;
    else if (stb.load || stb.wrap) addrQ <= selBegin;
    else if (stb.inc)            addrQ <= addrQ + ADDR_ONE;
    else if (stb.dec)            addrQ <= addrQ - ADDR_ONE;
  end

  assign ramAddr    = addrQ;
  assign atBegin    = (addrQ == selBegin);
  assign atFinal    = (addrQ == selFinal);
  assign atPreFinal = ((addrQ + ADDR_ONE) == selFinal);
  assign sameEnds   = (selBegin == selFinal);

endmodule

// File: rtl/sas_ctrl.sv
module sas_ctrl
  import sas_pkg::*;
#(
  parameter int PROF_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              update,
  input  logic [PROF_W-1:0] profile,
  input  logic [2:0]        word0Mode,
  input  logic [2:0]        selMode,
  input  logic              selNoDwell,
  input  logic              timerExpire,
  input  logic              atBegin,
  input  logic              atFinal,
  input  logic              atPreFinal,
  input  logic              sameEnds,
  output logic [PROF_W-1:0] effSel,
  output stepStbT           stb,
  output logic              sweepDone,
  output logic              accClear
);

  logic              updQ;
  logic [PROF_W-1:0] profQ;
  logic [PROF_W-1:0] profQ2;
  logic              dirUpQ;
  logic              doneQ;
  logic              clrQ;

  logic      bidirMode;
  logic      startNow;
  logic      fallNow;
  logic      goUp;
  sweepKindT kind;

  assign bidirMode = (word0Mode == CODE_BIDIR);
  assign effSel    = bidirMode ? '0 : profQ;
  assign kind      = decodeKind(selMode);
  assign startNow  = updQ || ((profQ != profQ2) && !bidirMode);
  assign fallNow   = bidirMode && profQ2[0] && !profQ[0];
  assign goUp      = dirUpQ ? !atFinal : atBegin;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      updQ   <= 1'b0;
      profQ  <= '0;
      profQ2 <= '0;
    end else begin
      updQ   <= update;
      profQ  <= profile;
      profQ2 <= profQ;
    end
  end

  // Step decision: start beats a direction fall, which beats a timer expiry
  always_comb begin
    stb = '0;
    if (startNow) begin
      stb.load   = 1'b1;
      stb.reload = 1'b1;
    end else if (fallNow) begin
      stb.reload = 1'b1;
      stb.dec    = !atBegin;
    end else if (timerExpire) begin
      stb.reload = 1'b1;
      case (kind)
        KIND_RAMPUP: stb.inc = !atFinal;
        KIND_BIDIR: begin
          if (profQ[0]) stb.inc = !atFinal;
          else          stb.dec = !atBegin;
        end
        KIND_CBIDIR: begin
          if (!sameEnds) begin
            stb.inc = goUp;
            stb.dec = !goUp;
          end
        end
        KIND_RECIRC: begin
          if (atFinal) stb.wrap = 1'b1;
          else         stb.inc  = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirUpQ <= 1'b1;
      doneQ  <= 1'b0;
      clrQ   <= 1'b0;
    end else if (startNow) begin
      dirUpQ <= 1'b1;
      doneQ  <= (kind == KIND_RAMPUP) && !selNoDwell && sameEnds;
      clrQ   <= 1'b0;
    end else if (!fallNow && timerExpire) begin
      if (kind == KIND_CBIDIR && !sameEnds) dirUpQ <= goUp;
      if (kind == KIND_RAMPUP) begin
        if (!selNoDwell) begin
          if (!atFinal && atPreFinal) doneQ <= 1'b1;
        end else if (atFinal) begin
          doneQ <= 1'b1;
          clrQ  <= 1'b1;
        end
      end
    end
  end

  assign sweepDone = doneQ;
  assign accClear  = clrQ;

endmodule

// File: rtl/sweep_addr_seq.sv
module sweep_addr_seq
  import sas_pkg::*;
#(
  parameter int NUM_PROF = 4,
  parameter int ADDR_W   = 10,
  parameter int RATE_W   = 16,
  parameter int PROF_W   = $clog2(NUM_PROF)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       update,
  input  logic [PROF_W-1:0]          profile,
  input  logic [NUM_PROF*ADDR_W-1:0] cfgBegin,
  input  logic [NUM_PROF*ADDR_W-1:0] cfgFinal,
  input  logic [NUM_PROF*RATE_W-1:0] cfgRate,
  input  logic [NUM_PROF*3-1:0]      cfgMode,
  input  logic [NUM_PROF-1:0]        cfgNoDwell,
  output logic [ADDR_W-1:0]          ramAddr,
  output logic                       sweepDone,
  output logic                       accClear
);

  stepStbT           stb;
  logic [PROF_W-1:0] effSel;
  logic [ADDR_W-1:0] selBegin;
  logic [ADDR_W-1:0] selFinal;
  logic [RATE_W-1:0] selRate;
  logic [2:0]        selMode;
  logic              selNoDwell;
  logic [2:0]        word0Mode;
  logic              timerExpire;
  logic              atBegin;
  logic              atFinal;
  logic              atPreFinal;
  logic              sameEnds;

  sas_cfg_bank #(
    .NUM_PROF(NUM_PROF), .ADDR_W(ADDR_W), .RATE_W(RATE_W), .PROF_W(PROF_W)
  ) uBank (
    .clk(clk), .rstN(rstN), .update(update),
    .cfgBegin(cfgBegin), .cfgFinal(cfgFinal), .cfgRate(cfgRate),
    .cfgMode(cfgMode), .cfgNoDwell(cfgNoDwell), .effSel(effSel),
    .selBegin(selBegin), .selFinal(selFinal), .selRate(selRate),
    .selMode(selMode), .selNoDwell(selNoDwell), .word0Mode(word0Mode)
  );

  sas_ctrl #(.PROF_W(PROF_W)) uCtrl (
    .clk(clk), .rstN(rstN), .update(update), .profile(profile),
    .word0Mode(word0Mode), .selMode(selMode), .selNoDwell(selNoDwell),
    .timerExpire(timerExpire), .atBegin(atBegin), .atFinal(atFinal),
    .atPreFinal(atPreFinal), .sameEnds(sameEnds), .effSel(effSel),
    .stb(stb), .sweepDone(sweepDone), .accClear(accClear)
  );

  sas_datapath #(.ADDR_W(ADDR_W), .RATE_W(RATE_W)) uPath (
    .clk(clk), .rstN(rstN), .stb(stb), .selBegin(selBegin),
    .selFinal(selFinal), .selRate(selRate), .ramAddr(ramAddr),
    .timerExpire(timerExpire), .atBegin(atBegin), .atFinal(atFinal),
    .atPreFinal(atPreFinal), .sameEnds(sameEnds)
  );

endmodule

// File: rtl/sas_checker.sv
module sas_checker
  import sas_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] ramAddr,
  input logic              sweepDone,
  input logic              accClear,
  input stepStbT           stb,
  input logic [ADDR_W-1:0] selBegin
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  assert_load_begin_R1: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> ramAddr == $past(selBegin));

  assert_single_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.load && !stb.wrap) |=>
      (ramAddr == $past(ramAddr) || ramAddr == $past(ramAddr) + ONE ||
       ramAddr == $past(ramAddr) - ONE));

  assert_done_parks_R3: assert property (@(posedge clk) disable iff (!rstN)
    (sweepDone && !stb.load) |=> (sweepDone && $stable(ramAddr)));

  assert_clear_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    (accClear && !stb.load) |=> accClear);

  assert_clear_with_done_R4: assert property (@(posedge clk) disable iff (!rstN)
    accClear |-> sweepDone);

endmodule

bind sweep_addr_seq sas_checker #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .ramAddr(ramAddr), .sweepDone(sweepDone),
  .accClear(accClear), .stb(stb), .selBegin(selBegin)
);

// File: tb/tb_sweep_addr_seq.sv
module tb_sweep_addr_seq;

  localparam int NP = 4;
  localparam int AW = 4;
  localparam int RW = 3;
  localparam int PW = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic update = 1'b0;
  logic [PW-1:0] profile = '0;
  logic [NP*AW-1:0] cfgBegin = '0;
  logic [NP*AW-1:0] cfgFinal = '0;
  logic [NP*RW-1:0] cfgRate = '0;
  logic [NP*3-1:0] cfgMode = '0;
  logic [NP-1:0] cfgNoDwell = '0;
  logic [AW-1:0] ramAddr;
  logic sweepDone;
  logic accClear;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sweep_addr_seq #(.NUM_PROF(NP), .ADDR_W(AW), .RATE_W(RW)) dut (
    .clk(clk), .rstN(rstN), .update(update), .profile(profile),
    .cfgBegin(cfgBegin), .cfgFinal(cfgFinal), .cfgRate(cfgRate),
    .cfgMode(cfgMode), .cfgNoDwell(cfgNoDwell),
    .ramAddr(ramAddr), .sweepDone(sweepDone), .accClear(accClear)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic setWord(input int p, input int mode, input int nd,
                         input int b, input int f, input int r);
    cfgBegin[p*AW +: AW] = AW'(b);
    cfgFinal[p*AW +: AW] = AW'(f);
    cfgRate[p*RW +: RW]  = RW'(r);
    cfgMode[p*3 +: 3]    = 3'(mode);
    cfgNoDwell[p]        = nd[0];
  endtask

  // Follow a sweep cycle by cycle; call right after the start edge
  task automatic trackCase(input string req, input int mode, input int nd,
                           input int b, input int f, input int r, input int len);
    for (int n = 0; n < len; n++) begin
      int re, k, l, ph, ea, ed, ec;
      @(negedge clk);
      re = (r == 0) ? 1 : r;
      k  = n / re;
      l  = f - b;
      ea = b; ed = 0; ec = 0;
      case (mode)
        1: begin
          ea = b + ((k < l) ? k : l);
          if (nd == 0) ed = (k >= l) ? 1 : 0;
          else begin ec = (k >= l + 1) ? 1 : 0; ed = ec; end
        end
        3: if (l > 0) begin
          ph = k % (2 * l);
          ea = (ph <= l) ? b + ph : b + 2 * l - ph;
        end
        4: ea = b + (k % (l + 1));
        default: ea = b;
      endcase
      chk(req, "ramAddr", int'(ramAddr), ea);
      chk(req, "sweepDone", int'(sweepDone), ed);
      chk(req, "accClear", int'(accClear), ec);
    end
  endtask

  task automatic runCase(input string req, input int p, input int mode, input int nd,
                         input int b, input int f, input int r, input int len);
    @(negedge clk);
    setWord(p, mode, nd, b, f, r);
    profile = PW'(p);
    update  = 1'b1;
    @(posedge clk);
    @(negedge clk);
    update = 1'b0;
    @(posedge clk);
    trackCase(req, mode, nd, b, f, r, len);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int modes[6] = '{1, 1, 3, 4, 5, 0};
    int nds[6]   = '{0, 1, 0, 0, 1, 0};
    int bs[3]    = '{2, 7, 0};
    int fs[3]    = '{5, 7, 3};
    string tags[6] = '{"R3", "R4", "R7", "R8", "R9", "R9"};
    int idx = 0;

    // R10: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10", "ramAddr", int'(ramAddr), 0);
    chk("R10", "sweepDone", int'(sweepDone), 0);
    chk("R10", "accClear", int'(accClear), 0);
    rstN = 1'b1;

    // Sweep every interval value (R2, including R=0) against each kind and end pair
    for (int m = 0; m < 6; m++)
      for (int r = 0; r < 8; r++)
        for (int e = 0; e < 3; e++) begin
          runCase(r == 0 ? "R2" : tags[m], 1 + (idx % 3), modes[m], nds[m],
                  bs[e], fs[e], r, 50);
          idx++;
        end

    // R1: profile change restarts with the new word, no update needed
    @(negedge clk);
    setWord(1, 3, 0, 2, 5, 1);
    setWord(2, 4, 0, 9, 12, 3);
    setWord(3, 6, 0, 14, 15, 2);
    profile = 2'd1;
    update = 1'b1;
    @(posedge clk);
    @(negedge clk);
    update = 1'b0;
    @(posedge clk);
    trackCase("R1", 3, 0, 2, 5, 1, 7);
    @(negedge clk);
    profile = 2'd2;
    @(posedge clk);
    @(posedge clk);
    trackCase("R1", 4, 0, 9, 12, 3, 20);
    @(negedge clk);
    profile = 2'd3;
    @(posedge clk);
    @(posedge clk);
    trackCase("R1", 6, 0, 14, 15, 2, 6);

    // R5/R6: direction-controlled operation on word 0
    @(negedge clk);
    setWord(0, 2, 1, 3, 6, 2);
    profile = 2'b11;
    update = 1'b1;
    @(posedge clk);
    @(negedge clk);
    update = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R1", "bidir start", int'(ramAddr), 3);
    repeat (12) @(negedge clk);
    chk("R5", "up saturate", int'(ramAddr), 6);
    chk("R9", "bidir done", int'(sweepDone), 0);
    chk("R9", "bidir clear", int'(accClear), 0);
    profile = 2'b01;
    repeat (4) @(negedge clk);
    chk("R6", "bit1 toggle no restart", int'(ramAddr), 6);
    profile = 2'b00;
    @(negedge clk);
    chk("R6", "before fall step", int'(ramAddr), 6);
    @(negedge clk);
    chk("R6", "immediate decrement", int'(ramAddr), 5);
    @(negedge clk);
    chk("R6", "timer reloaded", int'(ramAddr), 5);
    @(negedge clk);
    chk("R5", "down step", int'(ramAddr), 4);
    repeat (10) @(negedge clk);
    chk("R5", "down saturate", int'(ramAddr), 3);
    profile = 2'b10;
    repeat (4) @(negedge clk);
    chk("R5", "bit1 ignored", int'(ramAddr), 3);
    profile = 2'b01;
    repeat (10) @(negedge clk);
    chk("R5", "up again", int'(ramAddr), 6);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule